// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Unit

This block holds the status and interrupt logic for one asynchronous serial channel. A bit-level receiver hands it one character at a time. Each character comes with its parity result and the sampled stop bit. The block queues the character in a small receive FIFO, and each FIFO entry keeps its own error tags. On the transmit side, the block holds one byte in a transmit data register. It passes that byte to the transmitter's shift register whenever the shift register reports that it is empty.

The block also watches a carrier-detect pin and a clear-to-send pin. Both pins go through a two-stage synchroniser before any other logic uses them. A flag from a DMA engine can claim the receive path for that engine. A CPU reaches the block through a two-bit address with read and write strobes, and can read the status, write and read the control byte, pop received bytes and write the byte to transmit. The status byte and a single level-sensitive interrupt request are also driven straight out as ports.

Register addresses: 0 is status (read), 1 is control (read/write), 2 is data (a read pops the receive FIFO, a write loads the transmit register). Status bits: [0] receive data available, [1] overrun, [2] parity error, [3] framing error, [4] carrier detect, [5] transmit register empty, [7:6] zero. Control bits: [0] receive interrupt enable, [1] transmit interrupt enable, [2] carrier-detect auto-enable, [3] CTS auto-enable, [7] error-flag reset (acts when written as 1 and reads back 0).

Top module: `uart_stat_irq`

## Requirements
- R1: After reset the status byte reads 0x20 (only bit 5, transmit empty, set), the control byte reads 0 and irq is low.
- R2: The receive FIFO holds 4 characters in arrival order. A data read (address 2) returns the oldest character and removes it. Status bit 0 is 1 while the FIFO is not empty.
- R3: A character that arrives while the FIFO is full and no pop happens in the same cycle is dropped, and it sets the overrun bit (status bit 1).
- R4: A character whose stop bit is sampled as 0 carries a framing tag, and a character flagged by the receiver carries a parity tag. Status bits 3 and 2 latch these tags only once that character becomes the oldest FIFO entry, one cycle after it does.
- R5: Writing control with bit 7 = 1 clears the overrun, parity and framing bits. The same three bits clear while iostop is high, and while carrier-detect auto-enable is set and the synchronised carrier pin is high. A clear takes priority over a set in the same cycle.
- R6: Status bit 4 becomes 1 in the third rising edge after the carrier pin rises. After the pin falls, the bit stays 1 until the first status read and then reads 0.
- R7: A write to address 2 clears status bit 5. tx_load is asserted with tx_data while the register is full and tx_sr_empty is high, and bit 5 sets again after that transfer. Bit 5 is forced to 1 while iostop is high.
- R8: While CTS auto-enable is set and the synchronised CTS pin is high, status bit 5 reads 0 unless iostop is high.
- R9: irq is high whenever the transmit interrupt enable is set and status bit 5 is 1.
- R10: With the receive interrupt enable set, data available raises irq only while dma_rx_claim is low.
- R11: With the receive interrupt enable set, irq is also raised by any set error bit, whatever the state of dma_rx_claim. A rising carrier pin also raises irq, and that request is withdrawn by a status read.
- R12: With both interrupt enables clear, irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity check failed for this character |
| rx_stop_bit | input | 1 | Sampled stop bit; 0 means a framing error |
| tx_sr_empty | input | 1 | Transmit shift register can accept a byte |
| tx_load | output | 1 | Byte handed to the shift register this cycle |
| tx_data | output | 8 | Byte being handed over |
| dcd_pin | input | 1 | Asynchronous carrier-detect pin |
| cts_pin | input | 1 | Asynchronous clear-to-send pin (high blocks) |
| dma_rx_claim | input | 1 | A DMA channel reads received data from this channel |
| iostop | input | 1 | I/O-stop mode |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register |
| status | output | 8 | Live status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the delayed framing report. In that test a bad character waits behind a clean one, so a design that flags errors at push time would show bit 3 a full read too early. It sweeps all four combinations of error tags, each through the FIFO, which catches swapped or missing tags. It also counts the synchroniser edges on the carrier pin, and it checks that the carrier bit stays 1 after the pin falls until the first status read. A design without the synchroniser, or one that clears the bit on the falling edge itself, fails those checks. Finally it sweeps every combination of interrupt enable and DMA claim, with the transmit register both empty and full, and adds an overrun under a DMA claim, so that a design gating error interrupts with the DMA flag is caught.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int ST_RDRF = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_PE   = 2;
    localparam int ST_FE   = 3;
    localparam int ST_DCD  = 4;
    localparam int ST_TDRE = 5;

    localparam int CT_ERR_RST = 7;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_ent_t;

    typedef struct packed {
        logic cts_auto;
        logic dcd_auto;
        logic tx_ie;
        logic rx_ie;
    } ctrl_t;

endpackage

// File: rtl/uart_pin_sync.sv
module uart_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_a,
    output logic [WIDTH-1:0] pin_s
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_a;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_s = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_tag_fifo.sv
module uart_rx_tag_fifo
    import uart_stat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  rx_ent_t push_ent,
    input  logic    pop,
    output rx_ent_t head,
    output logic    empty,
    output logic    full,
    output logic    drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_ent_t [DEPTH-1:0] mem;
        logic    [PW-1:0]    wp;
        logic    [PW-1:0]    rp;
        logic    [CW-1:0]    cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_pop, do_push;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CW'(DEPTH)) || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wp] = push_ent;
            st_d.wp           = wrap_inc(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = wrap_inc(st_q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign drop  = push && !do_push;
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sr_empty,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic              full
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = st_q.full && sr_empty;
        if (load) st_d.full = 1'b0;
        if (wr) begin
            st_d.full = 1'b1;
            st_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_data = st_q.data;
    assign full      = st_q.full;
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
    import uart_stat_pkg::*;
#(
    parameter int RX_DEPTH    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_err,
    input  logic              rx_stop_bit,
    input  logic              tx_sr_empty,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    input  logic              dcd_pin,
    input  logic              cts_pin,
    input  logic              dma_rx_claim,
    input  logic              iostop,
    input  logic [1:0]        cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic [7:0]        status,
    output logic              irq
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  ovr;
        logic  pe;
        logic  fe;
        logic  tag_done;
        logic  dcd;
        logic  dcd_evt;
        logic  dcd_prev;
    } stat_st_t;

    stat_st_t s_d, s_q;

    logic [1:0] pin_s;
    logic       dcd_s, cts_s;
    logic       stat_rd, ctl_wr, err_rst, data_rd, tdr_wr, err_clr;
    logic       fifo_empty, fifo_full, fifo_drop;
    rx_ent_t    fifo_head, rx_ent;
    logic       tdr_full, tdre, rdrf;

    uart_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_a ({cts_pin, dcd_pin}),
        .pin_s (pin_s)
    );
    assign dcd_s = pin_s[0];
    assign cts_s = pin_s[1];

    assign stat_rd = cpu_rd && (cpu_addr == ADDR_STAT);
    assign ctl_wr  = cpu_wr && (cpu_addr == ADDR_CTRL);
    assign err_rst = ctl_wr && cpu_wdata[CT_ERR_RST];
    assign data_rd = cpu_rd && (cpu_addr == ADDR_DATA);
    assign tdr_wr  = cpu_wr && (cpu_addr == ADDR_DATA);

    assign rx_ent = '{data: rx_data, par_err: rx_par_err, frm_err: ~rx_stop_bit};

    uart_rx_tag_fifo #(.DEPTH(RX_DEPTH)) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_valid),
        .push_ent (rx_ent),
        .pop      (data_rd),
        .head     (fifo_head),
        .empty    (fifo_empty),
        .full     (fifo_full),
        .drop     (fifo_drop)
    );

    uart_tx_hold i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (tdr_wr),
        .wdata     (cpu_wdata),
        .sr_empty  (tx_sr_empty),
        .load      (tx_load),
        .load_data (tx_data),
        .full      (tdr_full)
    );

    assign err_clr = err_rst || iostop || (s_q.ctrl.dcd_auto && dcd_s);

    always_comb begin
        s_d = s_q;
        if (ctl_wr) s_d.ctrl = ctrl_t'(cpu_wdata[3:0]);

        // carrier detect level bit and rising-edge request
        s_d.dcd_prev = dcd_s;
        if (dcd_s)        s_d.dcd = 1'b1;
        else if (stat_rd) s_d.dcd = 1'b0;
        if (dcd_s && !s_q.dcd_prev) s_d.dcd_evt = 1'b1;
        else if (stat_rd)           s_d.dcd_evt = 1'b0;

        // error flags: overrun on drop, tags latched once per head entry
        if (fifo_drop) s_d.ovr = 1'b1;
        if (!fifo_empty && !s_q.tag_done) begin
            s_d.pe       = s_q.pe | fifo_head.par_err;
            s_d.fe       = s_q.fe | fifo_head.frm_err;
            s_d.tag_done = 1'b1;
        end
        if (data_rd && !fifo_empty) s_d.tag_done = 1'b0;
        if (err_clr) begin
            s_d.ovr = 1'b0;
            s_d.pe  = 1'b0;
            s_d.fe  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdrf = !fifo_empty;
    assign tdre = iostop || (!tdr_full && !(s_q.ctrl.cts_auto && cts_s));

    always_comb begin
        status          = '0;
        status[ST_RDRF] = rdrf;
        status[ST_OVR]  = s_q.ovr;
        status[ST_PE]   = s_q.pe;
        status[ST_FE]   = s_q.fe;
        status[ST_DCD]  = s_q.dcd;
        status[ST_TDRE] = tdre;
    end

    assign irq = (s_q.ctrl.rx_ie && ((rdrf && !dma_rx_claim) || s_q.ovr || s_q.pe
                                     || s_q.fe || s_q.dcd_evt))
              || (s_q.ctrl.tx_ie && tdre);

    always_comb begin
        case (cpu_addr)
            ADDR_STAT: cpu_rdata = status;
            ADDR_CTRL: cpu_rdata = {4'b0, s_q.ctrl};
            ADDR_DATA: cpu_rdata = fifo_head.data;
            default:   cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cpu_addr,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic [7:0] cpu_wdata,
    input logic       iostop,
    input logic       rx_valid,
    input logic [7:0] status,
    input logic       irq,
    input logic       rx_ie,
    input logic       tx_ie,
    input logic       cts_auto,
    input logic       dcd_auto,
    input logic       cts_s,
    input logic       dcd_s,
    input logic       fifo_full
);
    logic err_wr;
    assign err_wr = cpu_wr && (cpu_addr == 2'd1) && cpu_wdata[7];

    AST_TDRE_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 2'd2) |=> (iostop || !status[5])); // R7
    AST_IOSTOP_TDRE: assert property (@(posedge clk) disable iff (!rst_n)
        iostop |-> status[5]); // R7
    AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_auto && cts_s && !iostop) |-> !status[5]); // R8
    AST_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ie && status[5]) |-> irq); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq); // R12
    AST_ERR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        err_wr |=> (status[3:1] == 3'b000)); // R5
    AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fifo_full && !(cpu_rd && cpu_addr == 2'd2) && !err_wr && !iostop
         && !(dcd_auto && dcd_s)) |=> status[1]); // R3
    AST_ERR_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && (status[3:1] != 3'b000)) |-> irq); // R11
endmodule

bind uart_stat_irq uart_stat_irq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_wdata (cpu_wdata),
    .iostop    (iostop),
    .rx_valid  (rx_valid),
    .status    (status),
    .irq       (irq),
    .rx_ie     (s_q.ctrl.rx_ie),
    .tx_ie     (s_q.ctrl.tx_ie),
    .cts_auto  (s_q.ctrl.cts_auto),
    .dcd_auto  (s_q.ctrl.dcd_auto),
    .cts_s     (cts_s),
    .dcd_s     (dcd_s),
    .fifo_full (fifo_full)
);

// File: tb/test_uart_stat_irq.sv
`timescale 1ns/1ps
module test_uart_stat_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_par_err = 1'b0;
    logic       rx_stop_bit = 1'b1;
    logic       tx_sr_empty = 1'b0;
    logic       tx_load;
    logic [7:0] tx_data;
    logic       dcd_pin = 1'b0;
    logic       cts_pin = 1'b0;
    logic       dma_rx_claim = 1'b0;
    logic       iostop = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_stat_irq i_uart_stat_irq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par_err(rx_par_err), .rx_stop_bit(rx_stop_bit), .tx_sr_empty(tx_sr_empty),
        .tx_load(tx_load), .tx_data(tx_data), .dcd_pin(dcd_pin), .cts_pin(cts_pin),
        .dma_rx_claim(dma_rx_claim), .iostop(iostop), .cpu_addr(cpu_addr),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .status(status), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input logic pe, input logic stop);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_par_err = pe; rx_stop_bit = stop;
        @(negedge clk);
        rx_valid = 1'b0; rx_par_err = 1'b0; rx_stop_bit = 1'b1;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 / R12: reset state
        chk("R1 status", status, 8'h20);
        chk("R12 irq", irq, 0);
        cpu_read(2'd1, rd);
        chk("R1 ctrl", rd, 0);

        // R2 / R3: fill, overrun, ordered drain
        for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i), 1'b0, 1'b1);
        chk("R2 rdrf", status[0], 1);
        chk("R3 no ovr yet", status[1], 0);
        push(8'hEE, 1'b0, 1'b1);
        chk("R3 ovr", status[1], 1);
        for (int i = 0; i < 4; i++) begin
            cpu_read(2'd2, rd);
            chk("R2 order", rd, 8'hA0 + i);
        end
        chk("R2 empty", status[0], 0);
        chk("R3 ovr sticky", status[1], 1);
        cpu_write(2'd1, 8'h80);
        chk("R5 err reset", status[3:1], 0);

        // R4: framing reported only at head
        push(8'h11, 1'b0, 1'b1);
        push(8'h22, 1'b0, 1'b0);
        cyc(3);
        chk("R4 fe hidden", status[3], 0);
        cpu_read(2'd2, rd);
        chk("R4 first", rd, 8'h11);
        cyc(2);
        chk("R4 fe at head", status[3], 1);
        chk("R4 pe clean", status[2], 0);
        cpu_read(2'd2, rd);
        chk("R4 second", rd, 8'h22);
        cpu_write(2'd1, 8'h80);
        chk("R5 cleared", status[3:1], 0);

        // R4: sweep of tag combinations
        for (int k = 0; k < 4; k++) begin
            push(8'h30 + 8'(k), k[0], ~k[1]);
            cyc(2);
            chk("R4 pe tag", status[2], k & 1);
            chk("R4 fe tag", status[3], (k >> 1) & 1);
            cpu_read(2'd2, rd);
            chk("R4 data", rd, 8'h30 + k);
            cpu_write(2'd1, 8'h80);
            chk("R5 sweep clr", status[3:1], 0);
        end

        // R5: iostop clear
        push(8'h44, 1'b0, 1'b0);
        cyc(2);
        chk("R5 fe set", status[3], 1);
        iostop = 1'b1;
        cyc(1);
        chk("R5 iostop clr", status[3], 0);
        chk("R7 iostop tdre", status[5], 1);
        iostop = 1'b0;
        cpu_read(2'd2, rd);

        // R5: carrier auto-enable clear
        cpu_write(2'd1, 8'h04);
        push(8'h55, 1'b0, 1'b0);
        cyc(2);
        chk("R5 fe before dcd", status[3], 1);
        dcd_pin = 1'b1;
        cyc(4);
        chk("R5 dcd auto clr", status[3], 0);
        dcd_pin = 1'b0;
        cyc(4);
        cpu_read(2'd0, rd);
        cpu_read(2'd2, rd);
        cpu_write(2'd1, 8'h00);
        cyc(1);
        chk("R6 dcd cleared", status[4], 0);

        // R6 / R11: carrier bit timing and request
        cpu_write(2'd1, 8'h01);
        chk("R11 no irq", irq, 0);
        @(negedge clk); dcd_pin = 1'b1;
        cyc(2);
        chk("R6 sync delay", status[4], 0);
        cyc(1);
        chk("R6 dcd set", status[4], 1);
        chk("R11 dcd irq", irq, 1);
        cpu_read(2'd0, rd);
        chk("R11 irq withdrawn", irq, 0);
        chk("R6 dcd held high", status[4], 1);
        dcd_pin = 1'b0;
        cyc(5);
        chk("R6 dcd held", status[4], 1);
        cpu_read(2'd0, rd);
        chk("R6 read value", rd[4], 1);
        chk("R6 dcd read clr", status[4], 0);
        cpu_write(2'd1, 8'h00);

        // R7: transmit register
        cpu_write(2'd2, 8'h5A);
        chk("R7 tdre clr", status[5], 0);
        chk("R7 no load", tx_load, 0);
        tx_sr_empty = 1'b1;
        #1;
        chk("R7 load", tx_load, 1);
        chk("R7 data", tx_data, 8'h5A);
        @(negedge clk);
        tx_sr_empty = 1'b0;
        chk("R7 tdre set", status[5], 1);

        // R8: CTS hold
        cpu_write(2'd1, 8'h08);
        cts_pin = 1'b1;
        cyc(3);
        chk("R8 cts hold", status[5], 0);
        iostop = 1'b1;
        #1;
        chk("R8 iostop wins", status[5], 1);
        @(negedge clk);
        iostop = 1'b0;
        cts_pin = 1'b0;
        cyc(3);
        chk("R8 released", status[5], 1);

        // R9 / R10 / R12: enable x DMA sweep
        push(8'h77, 1'b0, 1'b1);
        for (int m = 0; m < 8; m++) begin
            cpu_write(2'd1, {6'b0, m[1], m[0]});
            dma_rx_claim = m[2];
            #1;
            chk("R10 irq tdre1", irq, ((m & 1) && !(m & 4)) || (m & 2) ? 1 : 0);
        end
        cpu_write(2'd2, 8'h99);
        for (int m = 0; m < 8; m++) begin
            cpu_write(2'd1, {6'b0, m[1], m[0]});
            dma_rx_claim = m[2];
            #1;
            chk("R9 irq tdre0", irq, ((m & 1) && !(m & 4)) ? 1 : 0);
        end

        // R11: error interrupt ignores DMA claim
        cpu_write(2'd1, 8'h01);
        dma_rx_claim = 1'b1;
        for (int i = 0; i < 4; i++) push(8'h60 + 8'(i), 1'b0, 1'b1);
        #1;
        chk("R3 ovr again", status[1], 1);
        chk("R11 err irq dma", irq, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule